// File: doc/BRIEF.md
# Serial HDLC Data Link Transmitter with Ping-Pong Message Buffer

This block sends a bit-oriented data link channel one bit per slot. A slot is marked by a single-cycle strobe from the carrier framer. While no message is pending it sends a steady stream of flag octets. A host fills an 8-byte message store through a small register port and then writes a control word. The control word names which 4-byte half of the store to send next, the last byte of that half to send, and whether the frame check sequence closes the frame after that block. The host then refills the other half while the transmitter drains the current one.

The transmitter latches each control word at a byte boundary. When it does, it pulses an interrupt that asks for the next control word. Data is sent with the least significant bit first and with zero-bit insertion for transparency. A block marked as final is followed by a 16-bit CRC and a closing flag. If no new control word arrives by the end of a non-final block, the frame is aborted. The host can also abort a frame at any slot, or force the whole channel to all ones.

Top module: `hdlc_link_tx`

## Requirements
- R1: Control bit 7 (link off), when set, forces `tx_bit` to 1 in every slot. When it is cleared, the idle flag pattern resumes, still aligned to its 8-slot octets.
- R2: With no message started, the output is a continuous stream of 0x7E octets sent LSB first (0,1,1,1,1,1,1,0), and `irq` stays low.
- R3: Host addresses 0 to 7 read and write the buffer bytes, and address 8 reads and writes the control word. The control word layout is: bit 0 send, bit 1 append-FCS, bit 2 abort, bits 5:3 pointer, bit 7 link off. Bit 6 and addresses 9 to 15 read as 0, and writes to addresses 9 to 15 change nothing.
- R4: At the end of an idle flag, a control word with send=1 is latched. Sending then starts at the first byte of the half picked by pointer bit 2, goes up in address order to the byte given by the full pointer, and sends each byte LSB first. `irq` pulses for exactly one cycle, and the send and append-FCS bits read back as 0 afterwards.
- R5: At the end of a block without append-FCS, a newly written control word with send=1 is latched. Sending continues with no gap from that word's half, and `irq` pulses again.
- R6: After a block with append-FCS, the transmitter sends the one's complement of a CRC-16. The CRC uses the polynomial x^16+x^12+x^5+1, is preset to all ones, and runs over the data bits. The complement is sent bit 0 first. One 0x7E closing flag and idle flags follow.
- R7: Inside the data and FCS fields, a 0 is inserted after every run of five 1s. Flags and abort runs are never stuffed.
- R8: If a non-final block ends and no new control word with send=1 has been written, the transmitter sends ABORT_LEN (8) ones and then returns to idle flags.
- R9: When the abort bit is set, the bit shown in the next slot is still sent. Then ABORT_LEN ones follow, then idle flags, and the abort bit reads back as 0.
- R10: After reset the control word and the buffer read 0, `irq` is low and `tx_bit` shows the first flag bit (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host address (log2(DEPTH)+1 bits) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from `host_addr` |
| slot_en | input | 1 | One-cycle strobe; the bit on `tx_bit` is taken in this cycle |
| tx_bit | output | 1 | Serial data link bit for the current slot |
| irq | output | 1 | One-cycle pulse on each control word latch |

## Verification
The streams tried are an idle channel, a two-byte frame that starts with 0xFF, and a full two-block frame containing 0x7E, 0x00 and 0xFF. A frame taken from the upper half alone is also sent. The two-byte frame shows whether insertion fires after exactly five ones. The 0x7E data byte shows that data is not mistaken for a flag. The upper-half frame shows that pointer bit 2 selects the half. Chained blocks are checked to keep one CRC across the half boundary, while an unrefilled control word and a host abort lead to the two different abort endings. A link-off window then shows whether flag alignment survives forced ones.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DATA  = 3'd1,
      ST_FCS   = 3'd2,
      ST_CLOSE = 3'd3,
      ST_ABORT = 3'd4
   } tx_state_t;

   localparam logic [7:0] FLAG_OCTET = 8'h7E;
   localparam int         RUN_LIMIT  = 5;
   localparam int         FCS_BITS   = 16;

   // One LSB-first CRC step with a bit-reversed polynomial.
   function automatic logic [FCS_BITS-1:0] crc_step(
      input logic [FCS_BITS-1:0] cur,
      input logic                din,
      input logic [FCS_BITS-1:0] poly_rev);
      logic fb;
      fb = cur[0] ^ din;
      return (cur >> 1) ^ (fb ? poly_rev : '0);
   endfunction

endpackage

// File: rtl/hdlc_tx_regs.sv
module hdlc_tx_regs #(
   parameter int DEPTH = 8,
   parameter int PW    = $clog2(DEPTH),
   parameter int AW    = PW + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_wr,
   input  logic [AW-1:0]         host_addr,
   input  logic [7:0]            host_wdata,
   output logic [7:0]            host_rdata,
   input  logic                  clr_msg,
   input  logic                  clr_abort,
   output logic [DEPTH-1:0][7:0] buf_flat,
   output logic                  send_q,
   output logic                  fcs_req_q,
   output logic                  abort_q,
   output logic [PW-1:0]         ptr_q,
   output logic                  link_off_q
);
   localparam logic [AW-1:0] CTRL_ADDR = AW'(DEPTH);
   localparam int            PTR_LSB   = 3;
   localparam logic [7:0]    USED_MASK = 8'h87 | (8'(DEPTH - 1) << PTR_LSB);

   logic [7:0] buf_q [DEPTH];
   logic       ctrl_wr;
   logic [7:0] ctrl_word;
   logic       unused_reserved;

   assign ctrl_wr         = host_wr && (host_addr == CTRL_ADDR);
   assign unused_reserved = ^(host_wdata & ~USED_MASK);

   for (genvar g = 0; g < DEPTH; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            buf_q[g] <= '0;
         else if (host_wr && host_addr == AW'(g))
            buf_q[g] <= host_wdata;
      end
      assign buf_flat[g] = buf_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         send_q     <= 1'b0;
         fcs_req_q  <= 1'b0;
         abort_q    <= 1'b0;
         ptr_q      <= '0;
         link_off_q <= 1'b0;
      end else if (ctrl_wr) begin
         send_q     <= host_wdata[0];
         fcs_req_q  <= host_wdata[1];
         abort_q    <= host_wdata[2];
         ptr_q      <= host_wdata[PTR_LSB +: PW];
         link_off_q <= host_wdata[7];
      end else begin
         if (clr_msg) begin
            send_q    <= 1'b0;
            fcs_req_q <= 1'b0;
         end
         if (clr_abort)
            abort_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_word              = '0;
      ctrl_word[0]           = send_q;
      ctrl_word[1]           = fcs_req_q;
      ctrl_word[2]           = abort_q;
      ctrl_word[PTR_LSB +: PW] = ptr_q;
      ctrl_word[7]           = link_off_q;
      if (!host_addr[AW-1])
         host_rdata = buf_q[host_addr[PW-1:0]];
      else if (host_addr == CTRL_ADDR)
         host_rdata = ctrl_word;
      else
         host_rdata = '0;
   end

endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
   parameter logic [15:0] POLY_REV = 16'h8408,
   parameter logic [15:0] PRESET   = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        step,
   input  logic        din,
   output logic [15:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= PRESET;
      else if (init)
         crc <= PRESET;
      else if (step)
         crc <= hdlc_tx_pkg::crc_step(crc, din, POLY_REV);
   end
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
   import hdlc_tx_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int PW        = $clog2(DEPTH),
   parameter int ABORT_LEN = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  slot_en,
   input  logic [DEPTH-1:0][7:0] buf_flat,
   input  logic                  send_q,
   input  logic                  fcs_req_q,
   input  logic                  abort_q,
   input  logic [PW-1:0]         ptr_q,
   input  logic [15:0]           crc,
   output logic                  bit_out,
   output logic                  irq,
   output logic                  clr_msg,
   output logic                  clr_abort,
   output logic                  crc_init,
   output logic                  crc_step_en,
   output logic                  crc_din,
   output tx_state_t             state
);
   localparam int ABW = (ABORT_LEN > 1) ? $clog2(ABORT_LEN) : 1;

   tx_state_t      state_q;
   logic [3:0]     bitcnt_q;
   logic [PW-1:0]  idx_q, stop_q;
   logic           fcs_q, stuff_q, irq_q;
   logic [2:0]     ones_q;
   logic [ABW-1:0] abcnt_q;

   logic raw, take, abort_go, latch, byte_end, in_frame, block_end;

   assign state     = state_q;
   assign irq       = irq_q;
   assign byte_end  = (bitcnt_q[2:0] == 3'd7);
   assign in_frame  = (state_q == ST_DATA) || (state_q == ST_FCS);
   assign block_end = (state_q == ST_DATA) && byte_end && (idx_q == stop_q);

   always_comb begin
      unique case (state_q)
         ST_DATA: raw = buf_flat[idx_q][bitcnt_q[2:0]];
         ST_FCS:  raw = ~crc[bitcnt_q];
         ST_ABORT: raw = 1'b1;
         default: raw = FLAG_OCTET[bitcnt_q[2:0]];
      endcase
   end

   assign bit_out     = stuff_q ? 1'b0 : raw;
   assign abort_go    = slot_en && abort_q && (state_q != ST_ABORT);
   assign take        = slot_en && !stuff_q && !abort_go;
   assign latch       = take && send_q && byte_end &&
                        ((state_q == ST_IDLE) || (block_end && !fcs_q));
   assign clr_msg     = latch;
   assign clr_abort   = abort_go;
   assign crc_init    = latch && (state_q == ST_IDLE);
   assign crc_step_en = take && (state_q == ST_DATA);
   assign crc_din     = raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         idx_q    <= '0;
         stop_q   <= '0;
         fcs_q    <= 1'b0;
         ones_q   <= '0;
         stuff_q  <= 1'b0;
         abcnt_q  <= '0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= latch;
         if (abort_go) begin
            state_q  <= ST_ABORT;
            abcnt_q  <= '0;
            stuff_q  <= 1'b0;
            ones_q   <= '0;
            bitcnt_q <= '0;
         end else if (slot_en && stuff_q) begin
            stuff_q <= 1'b0;
            ones_q  <= '0;
         end else if (take) begin
            if (in_frame) begin
               if (raw && ones_q == 3'(RUN_LIMIT - 1)) begin
                  stuff_q <= 1'b1;
                  ones_q  <= '0;
               end else begin
                  ones_q <= raw ? ones_q + 3'd1 : 3'd0;
               end
            end
            unique case (state_q)
               ST_IDLE, ST_CLOSE: begin
                  if (byte_end) begin
                     bitcnt_q <= '0;
                     state_q  <= ST_IDLE;
                  end else begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
               ST_DATA: begin
                  if (!byte_end) begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end else begin
                     bitcnt_q <= '0;
                     if (idx_q != stop_q)
                        idx_q <= idx_q + PW'(1);
                     else if (fcs_q)
                        state_q <= ST_FCS;
                     else if (!send_q) begin
                        state_q <= ST_ABORT;
                        abcnt_q <= '0;
                     end
                  end
               end
               ST_FCS: begin
                  if (bitcnt_q == 4'd15) begin
                     bitcnt_q <= '0;
                     state_q  <= ST_CLOSE;
                  end else begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
               ST_ABORT: begin
                  if (abcnt_q == ABW'(ABORT_LEN - 1)) begin
                     state_q  <= ST_IDLE;
                     bitcnt_q <= '0;
                  end else begin
                     abcnt_q <= abcnt_q + ABW'(1);
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
            if (latch) begin
               state_q  <= ST_DATA;
               bitcnt_q <= '0;
               idx_q    <= {ptr_q[PW-1], {(PW-1){1'b0}}};
               stop_q   <= ptr_q;
               fcs_q    <= fcs_req_q;
               if (state_q == ST_IDLE)
                  ones_q <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/hdlc_link_tx.sv
module hdlc_link_tx #(
   parameter int          DEPTH     = 8,
   parameter int          ABORT_LEN = 8,
   parameter logic [15:0] POLY_REV  = 16'h8408,
   parameter logic [15:0] PRESET    = 16'hFFFF,
   localparam int         PW        = $clog2(DEPTH),
   localparam int         AW        = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   input  logic          slot_en,
   output logic          tx_bit,
   output logic          irq
);
   if (DEPTH < 4 || DEPTH > 16 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two from 4 to 16");
   end
   if (ABORT_LEN < 7) begin : g_bad_abort
      $error("ABORT_LEN must be at least 7");
   end

   logic [DEPTH-1:0][7:0] buf_flat;
   logic                  ctrl_send, ctrl_fcs, ctrl_abort, ctrl_link_off;
   logic [PW-1:0]         ctrl_ptr;
   logic                  clr_msg, clr_abort;
   logic                  crc_init, crc_step_en, crc_din;
   logic [15:0]           crc;
   logic                  eng_bit;
   hdlc_tx_pkg::tx_state_t eng_state;

   hdlc_tx_regs #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .clr_msg    (clr_msg),
      .clr_abort  (clr_abort),
      .buf_flat   (buf_flat),
      .send_q     (ctrl_send),
      .fcs_req_q  (ctrl_fcs),
      .abort_q    (ctrl_abort),
      .ptr_q      (ctrl_ptr),
      .link_off_q (ctrl_link_off)
   );

   hdlc_tx_crc #(.POLY_REV(POLY_REV), .PRESET(PRESET)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .step  (crc_step_en),
      .din   (crc_din),
      .crc   (crc)
   );

   hdlc_tx_engine #(.DEPTH(DEPTH), .PW(PW), .ABORT_LEN(ABORT_LEN)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_en     (slot_en),
      .buf_flat    (buf_flat),
      .send_q      (ctrl_send),
      .fcs_req_q   (ctrl_fcs),
      .abort_q     (ctrl_abort),
      .ptr_q       (ctrl_ptr),
      .crc         (crc),
      .bit_out     (eng_bit),
      .irq         (irq),
      .clr_msg     (clr_msg),
      .clr_abort   (clr_abort),
      .crc_init    (crc_init),
      .crc_step_en (crc_step_en),
      .crc_din     (crc_din),
      .state       (eng_state)
   );

   assign tx_bit = ctrl_link_off | eng_bit;

endmodule

// File: rtl/hdlc_link_tx_chk.sv
module hdlc_link_tx_chk
   import hdlc_tx_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_wr,
   input logic [AW-1:0] host_addr,
   input logic          wr_off_bit,
   input logic          slot_en,
   input logic          tx_bit,
   input logic          irq,
   input tx_state_t     state,
   input logic          abort_bit,
   input logic          link_off
);
   logic       in_frame;
   logic [2:0] run_q;

   assign in_frame = (state == ST_DATA) || (state == ST_FCS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (slot_en)
         run_q <= (in_frame && tx_bit && !link_off) ? run_q + 3'd1 : 3'd0;
   end

   AST_OFF_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == AW'(DEPTH) && wr_off_bit) |=> tx_bit); // R1

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R4

   AST_IRQ_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(slot_en)); // R4

   AST_IRQ_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (state == ST_DATA)); // R2

   AST_STUFF_AFTER_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_en && in_frame && !link_off && tx_bit) |-> (run_q < 3'd5)); // R7

   AST_ABORT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_en && abort_bit && state != ST_ABORT && !host_wr)
         |=> (state == ST_ABORT && !abort_bit)); // R9

endmodule

bind hdlc_link_tx hdlc_link_tx_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .wr_off_bit (host_wdata[7]),
   .slot_en    (slot_en),
   .tx_bit     (tx_bit),
   .irq        (irq),
   .state      (eng_state),
   .abort_bit  (ctrl_abort),
   .link_off   (ctrl_link_off)
);

// File: tb/sim_hdlc_link_tx.sv
module sim_hdlc_link_tx;
   localparam logic [3:0] CTRL = 4'd8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       slot_en = 1'b0;
   logic       tx_bit, irq;

   int n_checks = 0;
   int n_fail = 0;
   int irq_seen = 0;
   bit exp_q[$];
   int ones_run;
   logic [15:0] crc_m;
   logic [7:0] mem [8];

   always #2 clk = ~clk;

   hdlc_link_tx u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .slot_en(slot_en),
      .tx_bit(tx_bit), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---- expected stream model ----
   function automatic void push_flag();
      for (int i = 0; i < 8; i++) exp_q.push_back(bit'((8'h7E >> i) & 8'h01));
   endfunction

   function automatic void push_ones(input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
   endfunction

   function automatic void push_stuffed(input bit b);
      exp_q.push_back(b);
      if (b) begin
         ones_run++;
         if (ones_run == 5) begin
            exp_q.push_back(1'b0);
            ones_run = 0;
         end
      end else begin
         ones_run = 0;
      end
   endfunction

   function automatic void frame_start();
      ones_run = 0;
      crc_m = 16'hFFFF;
   endfunction

   function automatic void push_data(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = crc_m[0] ^ b[i];
         crc_m = {1'b0, crc_m[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
         push_stuffed(b[i]);
      end
   endfunction

   function automatic void push_fcs();
      logic [15:0] f;
      f = ~crc_m;
      for (int i = 0; i < 16; i++) push_stuffed(f[i]);
   endfunction

   // ---- bus and slot helpers ----
   task automatic host_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic do_slot(output bit b, output bit iq);
      @(negedge clk);
      b = tx_bit;
      slot_en = 1'b1;
      @(negedge clk);
      slot_en = 1'b0;
      iq = irq;
   endtask

   task automatic run_n(input string tag, input int count);
      int bad = 0;
      for (int i = 0; i < count; i++) begin
         bit b, iq, e;
         do_slot(b, iq);
         e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
         if (b !== e) bad++;
         if (iq) irq_seen++;
      end
      chk(tag, bad, 0);
   endtask

   task automatic drain(input string tag);
      run_n(tag, exp_q.size());
   endtask

   // ---- scenarios ----
   task automatic t_reset();
      logic [7:0] d;
      chk("R10 tx_bit after reset", int'(tx_bit), 0);
      chk("R10 irq after reset", int'(irq), 0);
      host_read(CTRL, d);
      chk("R10 control after reset", int'(d), 0);
      host_read(4'd3, d);
      chk("R10 buffer after reset", int'(d), 0);
   endtask

   task automatic t_readback();
      logic [7:0] d;
      int bad = 0;
      for (int i = 0; i < 8; i++) host_write(4'(i), 8'(8'h11 * (i + 1)));
      for (int i = 0; i < 8; i++) begin
         host_read(4'(i), d);
         if (d !== 8'(8'h11 * (i + 1))) bad++;
      end
      chk("R3 buffer read-back", bad, 0);
      host_write(4'd12, 8'hC3);
      host_read(4'd12, d);
      chk("R3 unmapped address reads 0", int'(d), 0);
      host_read(4'd4, d);
      chk("R3 unmapped write leaves buffer", int'(d), 8'h55);
      host_write(CTRL, 8'h68);
      host_read(CTRL, d);
      chk("R3 control read-back, bit6 reads 0", int'(d), 8'h28);
      host_write(CTRL, 8'h00);
   endtask

   task automatic t_idle();
      irq_seen = 0;
      push_flag(); push_flag(); push_flag();
      drain("R2 idle flags");
      chk("R2 no irq while idle", irq_seen, 0);
   endtask

   task automatic t_short();
      logic [7:0] d;
      mem[0] = 8'hFF; mem[1] = 8'h3E;
      host_write(4'd0, mem[0]);
      host_write(4'd1, mem[1]);
      host_write(CTRL, 8'h0B);
      irq_seen = 0;
      push_flag();
      frame_start();
      push_data(mem[0]); push_data(mem[1]);
      push_fcs();
      push_flag();
      push_flag();
      drain("R6 R7 short frame stream");
      chk("R4 one irq for short frame", irq_seen, 1);
      host_read(CTRL, d);
      chk("R4 send and fcs bits cleared", int'(d), 8'h08);
   endtask

   task automatic t_two_block();
      logic [7:0] pat [8];
      pat = '{8'h7E, 8'h81, 8'h00, 8'hFF, 8'h55, 8'hF0, 8'h0F, 8'hAA};
      for (int i = 0; i < 8; i++) begin
         mem[i] = pat[i];
         host_write(4'(i), pat[i]);
      end
      host_write(CTRL, 8'h19);
      irq_seen = 0;
      push_flag();
      drain("R4 opening flag");
      chk("R4 irq on first latch", irq_seen, 1);
      host_write(CTRL, 8'h3B);
      frame_start();
      for (int i = 0; i < 8; i++) push_data(mem[i]);
      push_fcs();
      push_flag();
      drain("R5 R6 two-block frame stream");
      chk("R5 irq on chained latch", irq_seen, 2);
   endtask

   task automatic t_upper();
      host_write(CTRL, 8'h33);
      irq_seen = 0;
      push_flag();
      frame_start();
      for (int i = 4; i <= 6; i++) push_data(mem[i]);
      push_fcs();
      push_flag();
      drain("R4 upper half frame stream");
      chk("R4 irq for upper half frame", irq_seen, 1);
   endtask

   task automatic t_underrun();
      host_write(CTRL, 8'h19);
      irq_seen = 0;
      push_flag();
      frame_start();
      for (int i = 0; i < 4; i++) push_data(mem[i]);
      push_ones(8);
      push_flag();
      drain("R8 underrun abort stream");
      chk("R8 single irq on underrun", irq_seen, 1);
   endtask

   task automatic t_abort();
      logic [7:0] d;
      host_write(CTRL, 8'h19);
      push_flag();
      frame_start();
      for (int i = 0; i < 4; i++) push_data(mem[i]);
      run_n("R9 frame before abort", 20);
      host_write(CTRL, 8'h04);
      run_n("R9 pending bit still sent", 1);
      exp_q.delete();
      push_ones(8);
      push_flag();
      drain("R9 abort run then idle");
      host_read(CTRL, d);
      chk("R9 abort bit cleared", int'(d), 0);
   endtask

   task automatic t_disable();
      irq_seen = 0;
      host_write(CTRL, 8'h80);
      push_ones(16);
      drain("R1 link off forces ones");
      host_write(CTRL, 8'h00);
      push_flag();
      drain("R1 flags aligned after link on");
      chk("R1 no irq while off", irq_seen, 0);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_readback();
      t_idle();
      t_short();
      t_two_block();
      t_upper();
      t_underrun();
      t_abort();
      t_disable();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule